// File: doc/BRIEF.md
# Six-Flag Compare and Branch Unit

This block compares two signed operands and keeps six relation flags. The flags are greater, greater-or-equal, less, less-or-equal, equal and not-equal, each taken as the destination operand against the source operand. A compare strobe refreshes all six flags at once from the two operand values. The flags then hold until the next compare, so any number of branches can test the same result.

A branch decoder reads the registered flags and chooses the next program counter. It either forwards the sequential PC supplied by the fetch side or substitutes the branch target when the selected condition holds. A context port can load all six flags in parallel, so a scheduler can restore a thread's condition state after a switch.

All pins are plain control or data. The block has no stream interface: strobes are single-cycle qualifiers with no back-pressure, and `npc_o` is valid in every cycle.

Top module: `cbu_top`

## Requirements
- R1: After a synchronous reset (`rst_i` high), `flags_o` is 6'b000000.
- R2: On the clock edge after `cmp_i` is high (with `ctx_ld_i` low), `flags_o` takes the relation of `dst_i` to `src_i`. The bit positions are: bit0 greater, bit1 greater-or-equal, bit2 less, bit3 less-or-equal, bit4 equal, bit5 not-equal. Every bit is recomputed, and none keeps its old value.
- R3: Operands are 32-bit two's complement and every relation is signed, so 32'hFFFFFFFF is less than 1 and 32'h80000000 is less than 32'h7FFFFFFF.
- R4: While neither `cmp_i` nor `ctx_ld_i` is high, `flags_o` keeps its value, and branches do not change it.
- R5: With `br_i` high, `br_kind_i` selects the condition: 0 always, 1 not-equal (bit5), 2 equal (bit4), 3 less (bit2), 4 less-or-equal (bit3), 5 greater (bit0), 6 greater-or-equal (bit1). When the condition holds, `npc_o` equals `br_tgt_i` in the same cycle.
- R6: When `br_i` is low, when the selected flag is clear, or when `br_kind_i` is 7, `npc_o` equals `pc_seq_i`.
- R7: A branch in the same cycle as a compare tests the flags from before that compare.
- R8: `ctx_ld_i` loads `ctx_flags_i` into all six flags on the next edge. It has priority over a compare in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cmp_i | input | 1 | Compare strobe |
| src_i | input | 32 | Source operand (signed) |
| dst_i | input | 32 | Destination operand (signed) |
| br_i | input | 1 | Branch strobe |
| br_kind_i | input | 3 | Branch condition code |
| br_tgt_i | input | 32 | Branch target PC |
| pc_seq_i | input | 32 | Sequential next PC |
| ctx_ld_i | input | 1 | Context flag load strobe |
| ctx_flags_i | input | 6 | Flag values to load |
| flags_o | output | 6 | Registered relation flags |
| npc_o | output | 32 | Selected next PC |

## Verification
The flags are due one edge after a compare or a context load. `npc_o` is combinational, so it is due in the same cycle as the branch strobe and uses the flags registered before that edge. The bench drives inputs on the falling edge and checks `npc_o` a moment later against its model's current flags. On the following rising edge it updates the model's flags, and it checks `flags_o` at the next falling edge, one cycle after the stimulus.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int FLAG_N = 6;

  typedef enum logic [2:0] {
    BR_ALWAYS = 3'd0,
    BR_NE     = 3'd1,
    BR_EQ     = 3'd2,
    BR_LT     = 3'd3,
    BR_LE     = 3'd4,
    BR_GT     = 3'd5,
    BR_GE     = 3'd6,
    BR_RSVD   = 3'd7
  } br_kind_e;

  // bit0 gt .. bit5 ne
  typedef struct packed {
    logic ne;
    logic eq;
    logic le;
    logic lt;
    logic ge;
    logic gt;
  } rel_flags_t;
endpackage

// File: rtl/cbu_rel_eval.sv
module cbu_rel_eval
  import cbu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output rel_flags_t        rel_o
);
  logic signed [DATA_W-1:0] d_s, s_s;
  logic is_gt, is_eq;

  assign d_s = dst_i;
  assign s_s = src_i;

  always_comb begin
    is_gt = d_s > s_s;
    is_eq = d_s == s_s;
    rel_o = '0;
    rel_o.gt = is_gt;
    rel_o.eq = is_eq;
    rel_o.ge = is_gt | is_eq;
    rel_o.lt = ~(is_gt | is_eq);
    rel_o.le = ~is_gt;
    rel_o.ne = ~is_eq;
  end
endmodule

// File: rtl/cbu_flag_reg.sv
module cbu_flag_reg
  import cbu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       cmp_en_i,
  input  rel_flags_t cmp_val_i,
  input  logic       ld_en_i,
  input  rel_flags_t ld_val_i,
  output rel_flags_t q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)         q_o <= '0;
    else if (ld_en_i)  q_o <= ld_val_i;
    else if (cmp_en_i) q_o <= cmp_val_i;
  end

  // R4: idle cycles keep the flags
  a_r4_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cmp_en_i && !ld_en_i) |=> $stable(q_o));

  // R8: a load wins over a compare
  a_r8_restore: assert property (@(posedge clk_i) disable iff (rst_i)
    ld_en_i |=> (q_o == $past(ld_val_i)));
endmodule

// File: rtl/cbu_branch_sel.sv
module cbu_branch_sel
  import cbu_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  rel_flags_t      flags_i,
  input  logic            br_i,
  input  logic [2:0]      kind_i,
  input  logic [PC_W-1:0] tgt_i,
  input  logic [PC_W-1:0] seq_i,
  output logic [PC_W-1:0] npc_o
);
  logic cond;

  always_comb begin
    unique case (br_kind_e'(kind_i))
      BR_ALWAYS: cond = 1'b1;
      BR_NE:     cond = flags_i.ne;
      BR_EQ:     cond = flags_i.eq;
      BR_LT:     cond = flags_i.lt;
      BR_LE:     cond = flags_i.le;
      BR_GT:     cond = flags_i.gt;
      BR_GE:     cond = flags_i.ge;
      default:   cond = 1'b0;
    endcase
  end

  assign npc_o = (br_i && cond) ? tgt_i : seq_i;

  // R6: the reserved code never redirects
  a_r6_rsvd_seq: assert property (@(posedge clk_i) disable iff (rst_i)
    (br_i && kind_i == 3'd7) |-> (npc_o == seq_i));
endmodule

// File: rtl/cbu_top.sv
module cbu_top
  import cbu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cmp_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic              br_i,
  input  logic [2:0]        br_kind_i,
  input  logic [PC_W-1:0]   br_tgt_i,
  input  logic [PC_W-1:0]   pc_seq_i,
  input  logic              ctx_ld_i,
  input  logic [5:0]        ctx_flags_i,
  output logic [5:0]        flags_o,
  output logic [PC_W-1:0]   npc_o
);
  rel_flags_t rel_now, flags_q;

  cbu_rel_eval #(.DATA_W(DATA_W)) u_eval (
    .dst_i(dst_i), .src_i(src_i), .rel_o(rel_now)
  );

  cbu_flag_reg u_flags (
    .clk_i(clk_i), .rst_i(rst_i),
    .cmp_en_i(cmp_i), .cmp_val_i(rel_now),
    .ld_en_i(ctx_ld_i), .ld_val_i(rel_flags_t'(ctx_flags_i)),
    .q_o(flags_q)
  );

  cbu_branch_sel #(.PC_W(PC_W)) u_br (
    .clk_i(clk_i), .rst_i(rst_i), .flags_i(flags_q),
    .br_i(br_i), .kind_i(br_kind_i), .tgt_i(br_tgt_i),
    .seq_i(pc_seq_i), .npc_o(npc_o)
  );

  assign flags_o = flags_q;

  // R2: equal operands give ge, le, eq only
  a_r2_equal: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmp_i && !ctx_ld_i && dst_i == src_i) |=> (flags_o == 6'b011010));

  // R3: signed less-than sets lt and clears gt
  a_r3_signed_lt: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmp_i && !ctx_ld_i && $signed(dst_i) < $signed(src_i)) |=> (flags_o[2] && !flags_o[0]));

  // R5: unconditional branch always redirects
  a_r5_always: assert property (@(posedge clk_i) disable iff (rst_i)
    (br_i && br_kind_i == 3'd0) |-> (npc_o == br_tgt_i));
endmodule

// File: tb/cbu_top_test.sv
module cbu_top_test;
  logic        clk = 1'b0;
  logic        rst_i = 1'b1;
  logic        cmp_i = 1'b0;
  logic [31:0] src_i = '0;
  logic [31:0] dst_i = '0;
  logic        br_i = 1'b0;
  logic [2:0]  br_kind_i = '0;
  logic [31:0] br_tgt_i = '0;
  logic [31:0] pc_seq_i = '0;
  logic        ctx_ld_i = 1'b0;
  logic [5:0]  ctx_flags_i = '0;
  logic [5:0]  flags_o;
  logic [31:0] npc_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  logic [5:0] m_flags = '0;

  always #5 clk = ~clk;

  cbu_top uut (.*, .clk_i(clk));

  function automatic logic [5:0] relate(input logic signed [31:0] d, input logic signed [31:0] s);
    logic [5:0] f;
    f = '0;
    if (d > s)  f[0] = 1'b1;
    if (d >= s) f[1] = 1'b1;
    if (d < s)  f[2] = 1'b1;
    if (d <= s) f[3] = 1'b1;
    if (d == s) f[4] = 1'b1;
    if (d != s) f[5] = 1'b1;
    return f;
  endfunction

  function automatic bit takes(input logic [2:0] k, input logic [5:0] f);
    case (k)
      3'd0: return 1'b1;
      3'd1: return f[5];
      3'd2: return f[4];
      3'd3: return f[2];
      3'd4: return f[3];
      3'd5: return f[0];
      3'd6: return f[1];
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit c, input logic [31:0] d, input logic [31:0] s,
                      input bit b, input logic [2:0] k, input logic [31:0] t,
                      input bit l, input logic [5:0] lv);
    logic [31:0] exp_pc, seq;
    @(negedge clk);
    seq = $urandom;
    cmp_i = c; dst_i = d; src_i = s; br_i = b; br_kind_i = k;
    br_tgt_i = t; pc_seq_i = seq; ctx_ld_i = l; ctx_flags_i = lv;
    #1;
    exp_pc = (b && takes(k, m_flags)) ? t : seq;
    check({tag, " flags"}, {26'd0, flags_o}, {26'd0, m_flags});
    check({tag, " npc"}, npc_o, exp_pc);
    @(posedge clk);
    if (l) m_flags = lv;
    else if (c) m_flags = relate(d, s);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_i = 1'b0;
    // R1: reset state
    step("R1", 0, 0, 0, 0, 0, 32'h10, 0, 0);
    // R2: greater
    step("R2", 1, 5, 3, 0, 0, 0, 0, 0);
    // R5: every kind against gt result, R4 flags held across branches
    for (int k = 0; k < 7; k++) step("R5", 0, 0, 0, 1, 3'(k), 32'h100 + k, 0, 0);
    step("R4", 0, 9, 1, 0, 0, 0, 0, 0);
    // equal result
    step("R2", 1, 7, 7, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 1, 3'd1, 32'h200, 0, 0);
    step("R5", 0, 0, 0, 1, 3'd2, 32'h204, 0, 0);
    step("R5", 0, 0, 0, 1, 3'd4, 32'h208, 0, 0);
    step("R6", 0, 0, 0, 1, 3'd5, 32'h20c, 0, 0);
    // R3: signed comparisons
    step("R3", 1, 32'hFFFFFFFF, 1, 0, 0, 0, 0, 0);
    step("R3", 1, 32'h80000000, 32'h7FFFFFFF, 1, 3'd3, 32'h300, 0, 0);
    step("R3", 1, 1, 32'hFFFFFFFF, 1, 3'd3, 32'h304, 0, 0);
    step("R3", 0, 0, 0, 1, 3'd5, 32'h308, 0, 0);
    // R7: compare giving equal alongside eq branch tests old gt flags
    step("R7", 1, 4, 4, 1, 3'd2, 32'h400, 0, 0);
    step("R7", 0, 0, 0, 1, 3'd2, 32'h404, 0, 0);
    // R6: reserved kind and idle strobe
    step("R6", 0, 0, 0, 1, 3'd7, 32'h500, 0, 0);
    step("R6", 0, 0, 0, 0, 3'd0, 32'h504, 0, 0);
    // R8: load wins over compare
    step("R8", 1, 9, 1, 0, 0, 0, 1, 6'b100101);
    step("R8", 0, 0, 0, 1, 3'd1, 32'h600, 0, 0);
    step("R8", 1, 2, 2, 0, 0, 0, 1, 6'b010010);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0);
    // mixed patterns against the model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, bb;
      a = $urandom; bb = ($urandom % 4 == 0) ? a : $urandom;
      if ($urandom % 3 == 0) bb = a + 32'($urandom % 3) - 1;
      step("R2", ($urandom % 2) == 1, a, bb, ($urandom % 2) == 1, 3'($urandom),
           $urandom, ($urandom % 9) == 0, 6'($urandom));
    end
    // R1: reset clears flags again
    @(negedge clk); rst_i = 1'b1;
    @(posedge clk); m_flags = '0;
    @(negedge clk); rst_i = 1'b0;
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule